// File: doc/BRIEF.md
# Trap Instruction Control Sequencer

This block sequences a system-call trap and its matching return for a 16-bit processor core. When decode has recognised a trap instruction, it pulses a start strobe and presents the 8-bit service number together with the program counter. That program counter was already advanced during fetch, so it already points at the next instruction. The sequencer zero-extends the service number into an address within a 256-word table of routine entry points at the bottom of memory. It reads that table word through a memory read port with a ready handshake. In one commit cycle it then writes the saved next-instruction address into the fixed link register and loads the table word into the program counter. One cycle later it pulses a done strobe.

A return request in the idle state loads the program counter from the link register value supplied by the register file. This takes one cycle and needs no memory access. While a trap is in flight, new start or return requests are ignored. All outputs to the core are decoded from one state register, and every value they carry comes from a register captured inside the block.

Top module: `trap_seq`

## Requirements
- R1: After reset the block is idle. `busy_o`, `mem_req_o`, `rf_we_o`, `pc_ld_o` and `done_o` are all 0.
- R2: A `start_i` sampled high while idle raises `mem_req_o` in the next cycle. `mem_addr_o` equals `TABLE_BASE` plus the zero-extended `vector_i` captured at that edge, and `busy_o` is 1.
- R3: While `mem_req_o` is high and `mem_rdy_i` is low, the request stays high and `mem_addr_o` stays unchanged. No link write and no program counter load happen during that time.
- R4: In the cycle after the edge where `mem_rdy_i` is sampled high during a request, `rf_we_o` is 1 and `rf_waddr_o` is 7. `rf_wdata_o` carries the `pc_i` value captured at start. In the same cycle `pc_ld_o` is 1 and `pc_val_o` carries the `mem_data_i` value sampled with the ready.
- R5: `done_o` is high for exactly the one cycle after the commit cycle. The block is idle (`busy_o` 0) in the cycle after that.
- R6: `start_i` while busy has no effect. The table address, the link data and the loaded program counter all stay those of the trap already in flight.
- R7: A `ret_i` sampled high while idle, with `start_i` low, makes `pc_ld_o` 1 in the next cycle, with `pc_val_o` equal to the `link_i` value sampled at that edge. `mem_req_o`, `rf_we_o` and `done_o` stay 0, and the block is idle again one cycle later.
- R8: When `start_i` and `ret_i` are both high while idle, the trap wins. A table request follows, and no return load occurs.
- R9: `ret_i` while busy has no effect. No extra program counter load occurs, and the trap sequence continues unchanged.
- R10: The extreme vectors 8'h00 and 8'hFF address words `TABLE_BASE` and `TABLE_BASE`+255. The table address never leaves that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Trap start strobe from decode |
| ret_i | input | 1 | Return (jump through link register) strobe |
| vector_i | input | 8 | Trap service number |
| pc_i | input | 16 | Already-incremented program counter |
| link_i | input | 16 | Current link register value from the register file |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 16 | Table read address |
| mem_rdy_i | input | 1 | Memory has valid read data this cycle |
| mem_data_i | input | 16 | Memory read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write index (always the link register) |
| rf_wdata_o | output | 16 | Register file write data (return address) |
| pc_ld_o | output | 1 | Program counter load strobe |
| pc_val_o | output | 16 | New program counter value |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | One-cycle pulse ending a trap |

## Verification
The assertions check several rules on every cycle:

- A stalled request keeps its address steady.
- Every accepted read leads to a combined link write and program counter load.
- Every commit is followed by a done pulse and then by idle.
- A return always loads the sampled link value without touching memory.
- The table address always stays within the 256-word window.

The assertions cannot show that the right values travel to the right places. That needs the bench's scenarios: the return address captured at start against the one written, the zero-extension of the extreme vectors, and the table word actually loaded. The same holds for the start-versus-return priority and for requests driven while a trap is in flight, which the bench covers with changed inputs and varying memory stalls.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  // Sequencer states; ST_RET is the single-cycle return load.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_COMMIT = 3'd2,
    ST_DONE   = 3'd3,
    ST_RET    = 3'd4
  } seq_state_e;

endpackage

// File: rtl/trap_seq_capture.sv
module trap_seq_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/trap_seq_addr.sv
module trap_seq_addr #(
  parameter int          XLEN       = 16,
  parameter int          VEC_W      = 8,
  parameter int unsigned TABLE_BASE = 0
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic [XLEN-1:0]  addr_o
);

  localparam logic [XLEN-1:0] BASE_V = XLEN'(TABLE_BASE);

  // Zero-extend the service number and offset it into the entry table.
  function automatic logic [XLEN-1:0] form_addr(input logic [VEC_W-1:0] v);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-VEC_W){1'b0}}, v};
    return BASE_V + ext;
  endfunction

  assign addr_o = form_addr(vec_i);

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ret_i,
  input  logic       mem_rdy_i,
  output seq_state_e state_o,
  output logic       trap_go_o,
  output logic       ret_go_o,
  output logic       fetch_ok_o
);

  seq_state_e state_q, state_d;

  // Start has priority over return; both are only heard in idle.
  assign trap_go_o  = (state_q == ST_IDLE) && start_i;
  assign ret_go_o   = (state_q == ST_IDLE) && ret_i && !start_i;
  assign fetch_ok_o = (state_q == ST_FETCH) && mem_rdy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trap_go_o)     state_d = ST_FETCH;
        else if (ret_go_o) state_d = ST_RET;
      end
      ST_FETCH:  if (fetch_ok_o) state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      ST_RET:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R5
  commit_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMMIT) |=> (state_q == ST_DONE));

  // R6
  busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && !mem_rdy_i && start_i) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int          XLEN       = 16,
  parameter int          VEC_W      = 8,
  parameter int          RF_AW      = 3,
  parameter int          LINK_REG   = 7,
  parameter int unsigned TABLE_BASE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ret_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  link_i,
  output logic             mem_req_o,
  output logic [XLEN-1:0]  mem_addr_o,
  input  logic             mem_rdy_i,
  input  logic [XLEN-1:0]  mem_data_i,
  output logic             rf_we_o,
  output logic [RF_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o,
  output logic             pc_ld_o,
  output logic [XLEN-1:0]  pc_val_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [RF_AW-1:0] LINK_IDX = RF_AW'(LINK_REG);
  localparam longint unsigned  WIN_LO   = longint'(TABLE_BASE);
  localparam longint unsigned  WIN_HI   = WIN_LO + (longint'(1) << VEC_W);

  seq_state_e       state;
  logic             trap_go, ret_go, fetch_ok;
  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0]  ret_addr_q, entry_q, link_q, tbl_addr;

  trap_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ret_i      (ret_i),
    .mem_rdy_i  (mem_rdy_i),
    .state_o    (state),
    .trap_go_o  (trap_go),
    .ret_go_o   (ret_go),
    .fetch_ok_o (fetch_ok)
  );

  trap_seq_capture #(.W(VEC_W)) u_vec_reg (
    .clk(clk), .rst_n(rst_n), .en(trap_go), .d(vector_i), .q(vec_q)
  );

  trap_seq_capture #(.W(XLEN)) u_ret_reg (
    .clk(clk), .rst_n(rst_n), .en(trap_go), .d(pc_i), .q(ret_addr_q)
  );

  trap_seq_capture #(.W(XLEN)) u_entry_reg (
    .clk(clk), .rst_n(rst_n), .en(fetch_ok), .d(mem_data_i), .q(entry_q)
  );

  trap_seq_capture #(.W(XLEN)) u_link_reg (
    .clk(clk), .rst_n(rst_n), .en(ret_go), .d(link_i), .q(link_q)
  );

  trap_seq_addr #(.XLEN(XLEN), .VEC_W(VEC_W), .TABLE_BASE(TABLE_BASE)) u_addr (
    .vec_i  (vec_q),
    .addr_o (tbl_addr)
  );

  assign mem_req_o  = (state == ST_FETCH);
  assign mem_addr_o = tbl_addr;
  assign rf_we_o    = (state == ST_COMMIT);
  assign rf_waddr_o = LINK_IDX;
  assign rf_wdata_o = ret_addr_q;
  assign pc_ld_o    = (state == ST_COMMIT) || (state == ST_RET);
  assign pc_val_o   = (state == ST_RET) ? link_q : entry_q;
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = (state == ST_DONE);

  // R3
  stall_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && !rf_we_o && !pc_ld_o));

  // R4
  commit_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> (rf_we_o && pc_ld_o && pc_val_o == $past(mem_data_i)));

  // R5
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |=> (done_o && !pc_ld_o) ##1 (!busy_o && !done_o));

  // R7
  ret_loads_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && ret_i && !start_i) |=>
      (pc_ld_o && pc_val_o == $past(link_i) && !mem_req_o && !rf_we_o && !done_o));

  // R2
  start_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> mem_req_o);

  // R10
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (longint'(mem_addr_o) >= WIN_LO && longint'(mem_addr_o) < WIN_HI));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !mem_req_o && !rf_we_o && !pc_ld_o && !done_o));

endmodule

// File: tb/test_trap_seq.sv
module test_trap_seq;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 8;

  // {interfere, vector[7:0], pc[15:0], table_word[15:0], waits[7:0]}
  localparam logic [48:0] VECS [N_VEC] = '{
    {1'b0, 8'h00, 16'h3001, 16'h0400, 8'd0},
    {1'b0, 8'hFF, 16'h3100, 16'h0F00, 8'd1},
    {1'b0, 8'h21, 16'h4002, 16'h0430, 8'd2},
    {1'b1, 8'h23, 16'h5555, 16'h04A0, 8'd0},
    {1'b1, 8'h25, 16'hFFFF, 16'hFD70, 8'd3},
    {1'b0, 8'h80, 16'h0000, 16'hFFFF, 8'd1},
    {1'b1, 8'h7F, 16'hA5A5, 16'h1234, 8'd2},
    {1'b0, 8'h20, 16'h3FFF, 16'h0000, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, ret = 1'b0, mem_rdy = 1'b0;
  logic [7:0]  vec = '0;
  logic [15:0] pc = '0, link = '0, mem_data = '0;
  logic        mem_req, rf_we, pc_ld, busy, done;
  logic [15:0] mem_addr, rf_wdata, pc_val;
  logic [2:0]  rf_waddr;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_seq i_trap_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ret_i(ret),
    .vector_i(vec), .pc_i(pc), .link_i(link),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdy_i(mem_rdy), .mem_data_i(mem_data),
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .pc_ld_o(pc_ld), .pc_val_o(pc_val), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // One trap with a stall of 'waits' cycles; with intf set, start and ret are
  // driven with foreign values for the whole sequence (R6, R9).
  task automatic run_trap(input logic intf, input logic [7:0] v, input logic [15:0] p,
                          input logic [15:0] w, input int waits);
    @(negedge clk);
    start = 1'b1; vec = v; pc = p; mem_rdy = 1'b0;
    @(negedge clk);
    start = intf; ret = intf; vec = ~v; pc = ~p; link = 16'h9999;
    chk("R2 mem_req", {15'b0, mem_req}, 16'd1);
    chk("R2/R10 addr", mem_addr, {8'h00, v});
    chk("R2 busy", {15'b0, busy}, 16'd1);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R3 req held", {15'b0, mem_req}, 16'd1);
      chk("R3/R6 addr stable", mem_addr, {8'h00, v});
      chk("R3/R9 no load", {14'b0, rf_we, pc_ld}, 16'd0);
    end
    mem_rdy = 1'b1; mem_data = w;
    @(negedge clk);
    mem_rdy = 1'b0; mem_data = 16'hDEAD;
    chk("R4 rf_we", {15'b0, rf_we}, 16'd1);
    chk("R4 waddr", {13'b0, rf_waddr}, 16'd7);
    chk("R4/R6 link data", rf_wdata, p);
    chk("R4 pc_ld", {15'b0, pc_ld}, 16'd1);
    chk("R4 pc_val", pc_val, w);
    chk("R4 no req", {15'b0, mem_req}, 16'd0);
    @(negedge clk);
    chk("R5 done", {15'b0, done}, 16'd1);
    chk("R5/R9 no pc_ld", {15'b0, pc_ld}, 16'd0);
    start = 1'b0; ret = 1'b0;
    @(negedge clk);
    chk("R5 idle", {14'b0, busy, done}, 16'd0);
    chk("R6/R9 no reload", {14'b0, pc_ld, mem_req}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset outputs", {11'b0, busy, mem_req, rf_we, pc_ld, done}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {11'b0, busy, mem_req, rf_we, pc_ld, done}, 16'd0);

    for (int k = 0; k < N_VEC; k++) begin
      run_trap(VECS[k][48], VECS[k][47:40], VECS[k][39:24], VECS[k][23:8], int'(VECS[k][7:0]));
    end

    // R7: return in idle
    @(negedge clk);
    ret = 1'b1; link = 16'hBEEF;
    @(negedge clk);
    ret = 1'b0; link = 16'h0000;
    chk("R7 pc_ld", {15'b0, pc_ld}, 16'd1);
    chk("R7 pc_val", pc_val, 16'hBEEF);
    chk("R7 no mem/rf/done", {13'b0, mem_req, rf_we, done}, 16'd0);
    @(negedge clk);
    chk("R7 back to idle", {14'b0, busy, pc_ld}, 16'd0);

    // R8: start and return together
    start = 1'b1; ret = 1'b1; vec = 8'h42; pc = 16'h7000; link = 16'h1111;
    @(negedge clk);
    start = 1'b0; ret = 1'b0;
    chk("R8 trap wins req", {15'b0, mem_req}, 16'd1);
    chk("R8 no return load", {15'b0, pc_ld}, 16'd0);
    chk("R8 addr", mem_addr, 16'h0042);
    mem_rdy = 1'b1; mem_data = 16'h0500;
    @(negedge clk);
    mem_rdy = 1'b0;
    chk("R8 pc_val is table word", pc_val, 16'h0500);
    chk("R8 link data", rf_wdata, 16'h7000);
    repeat (2) @(negedge clk);
    chk("R8 idle", {15'b0, busy}, 16'd0);

    finish_run();
  end

endmodule